// File: doc/BRIEF.md
# Nibble-Command Stepper Motor Controller

This block sits between a command source and a linear stepping motor whose arm can rest at one of sixteen positions. The source hands over commands as 4-bit nibbles using a strobe and busy handshake. A move command is two nibbles long: an opcode, then a step count. A return-to-zero command is a single opcode nibble. The controller converts each command into a train of single-cycle pulses on `step` and holds a `direction` level while the pulses run.

The controller keeps its own record of the arm position and makes that count visible on `position`. The return-to-zero command uses this count to work out how many outward steps it needs. The same count lets the block refuse any step that would drive the arm past either end of its travel. The source waits for `busy` to go low before it offers the next command.

Top module: `stepper_cmd_ctrl`

## Requirements
- R1: Driving `rst_n` low clears `busy`, `step`, `direction` and `position` to zero at once. The release of reset is synchronised to `clk`.
- R2: While `busy` is low, `strobe` high with `cmd_nib` = 4'b1000 (move in) or 4'b0100 (move out) is accepted at that clock edge, and `busy` is high in the next cycle. `direction` then reads 1 for move in and 0 for move out.
- R3: For a move command, the step count is taken from `cmd_nib` on the first rising edge at which `busy` is already high. Later values on `cmd_nib` have no effect on that command.
- R4: A move command with count N issues exactly N pulses when no travel limit intervenes. A count of zero issues none. For example, 4'b0100 followed by 4'b0010 gives two outward pulses.
- R5: Each pulse on `step` is high for one cycle and is followed by at least one low cycle. `direction` already holds its final value in the cycle before the first pulse and keeps it through the last pulse.
- R6: `position` rises by one after each inward pulse, falls by one after each outward pulse, and otherwise holds.
- R7: A step that would take `position` above 15 or below 0 is not issued, so the position saturates at the ends of travel.
- R8: `cmd_nib` = 4'b0010 with `strobe` (return to zero) is a single-nibble command. It issues outward pulses until `position` reaches 0, and it issues none when `position` is already 0.
- R9: `strobe` with any other opcode is ignored: `busy` stays low and `position` does not change.
- R10: `busy` goes low in the second cycle after the last pulse (or after the count is found exhausted). A `strobe` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_nib | input | 4 | Command nibble from the source: opcode, then step count |
| strobe | input | 1 | High when an opcode nibble is on `cmd_nib` |
| busy | output | 1 | High while a command is recognised and running; also requests the second nibble |
| step | output | 1 | Single-cycle step pulses to the motor |
| direction | output | 1 | Motion direction: 1 inward, 0 outward |
| position | output | 4 | Tracked arm position, 0 to 15 |

## Verification
The bench drives the arm against both ends of travel. A controller without saturation would keep pulsing and let `position` wrap from 15 to 0 or from 0 to 15. It sends return-to-zero from position 15 and from position 0; an off-by-one in the count load would give 14 or 16 pulses, and a missing zero check would give a spurious pulse. It changes `cmd_nib` right after the count is captured and raises a return-to-zero strobe in the middle of a move. A design that samples late, or that accepts strobes while busy, would then change the pulse count or the final position. It also checks the two-cycle gap between the last pulse and busy falling, and the behaviour of undefined opcodes and count zero, which catch a controller that latches junk or emits a stray pulse.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  // Opcode nibbles recognised on the command bus
  localparam logic [3:0] OPC_MOVE_IN  = 4'b1000;
  localparam logic [3:0] OPC_MOVE_OUT = 4'b0100;
  localparam logic [3:0] OPC_HOME     = 4'b0010;

  // Controller sequencing states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for an opcode strobe
    ST_FETCH = 2'd1,  // busy raised, count nibble expected on the bus
    ST_CHECK = 2'd2,  // decide between another pulse and completion
    ST_PULSE = 2'd3   // step output high for this cycle
  } ctrl_state_e;

  // Decoded command class
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_IN   = 2'd1,
    OP_OUT  = 2'd2,
    OP_HOME = 2'd3
  } op_kind_e;

endpackage

// File: rtl/stepper_rst_sync.sv
module stepper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/stepper_cmd_decode.sv
module stepper_cmd_decode
  import stepper_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] nib,
  output op_kind_e         kind
);

  localparam logic [NIB_W-1:0] CODE_IN   = NIB_W'(OPC_MOVE_IN);
  localparam logic [NIB_W-1:0] CODE_OUT  = NIB_W'(OPC_MOVE_OUT);
  localparam logic [NIB_W-1:0] CODE_HOME = NIB_W'(OPC_HOME);

  always_comb begin
    if (nib == CODE_IN) begin
      kind = OP_IN;
    end else if (nib == CODE_OUT) begin
      kind = OP_OUT;
    end else if (nib == CODE_HOME) begin
      kind = OP_HOME;
    end else begin
      kind = OP_NONE;
    end
  end

endmodule

// File: rtl/stepper_down_count.sv
module stepper_down_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] cnt_q,
  output logic         cnt_zero
);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_en   = load_en | (dec_en & ~cnt_zero);

  always_comb begin
    if (load_en) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/stepper_pos_track.sv
module stepper_pos_track #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         move_en,
  input  logic         move_in,
  output logic [W-1:0] pos_q,
  output logic         at_min,
  output logic         at_max
);

  logic [W-1:0] pos_d;
  logic         pos_en;

  assign at_min = (pos_q == '0);
  assign at_max = (pos_q == '1);
  assign pos_en = move_en & (move_in ? ~at_max : ~at_min);

  always_comb begin
    if (move_in) begin
      pos_d = pos_q + 1'b1;
    end else begin
      pos_d = pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/stepper_cmd_ctrl.sv
module stepper_cmd_ctrl
  import stepper_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int POS_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] cmd_nib,
  input  logic             strobe,
  output logic             busy,
  output logic             step,
  output logic             direction,
  output logic [POS_W-1:0] position
);

  localparam int CNT_W = (NIB_W > POS_W) ? NIB_W : POS_W;

  logic        rst_int_n;
  op_kind_e    op_kind;
  ctrl_state_e state_q;
  ctrl_state_e state_d;
  logic        dir_q;
  logic        dir_d;
  logic        dir_en;
  logic        accept;
  logic        cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic        cnt_dec;
  logic [CNT_W-1:0] cnt_q;
  logic        cnt_zero;
  logic        pos_move;
  logic        at_min;
  logic        at_max;
  logic        limit_hit;

  stepper_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  stepper_cmd_decode #(
    .NIB_W (NIB_W)
  ) u_decode (
    .nib  (cmd_nib),
    .kind (op_kind)
  );

  stepper_down_count #(
    .W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (cnt_load),
    .load_val (cnt_load_val),
    .dec_en   (cnt_dec),
    .cnt_q    (cnt_q),
    .cnt_zero (cnt_zero)
  );

  stepper_pos_track #(
    .W (POS_W)
  ) u_pos (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .move_en (pos_move),
    .move_in (dir_q),
    .pos_q   (position),
    .at_min  (at_min),
    .at_max  (at_max)
  );

  // A pulse is refused when the arm already sits at the end it moves toward
  assign limit_hit = dir_q ? at_max : at_min;
  assign accept    = (state_q == ST_IDLE) & strobe & (op_kind != OP_NONE);

  // Next-state and datapath control
  always_comb begin
    state_d      = state_q;
    cnt_load     = 1'b0;
    cnt_load_val = '0;
    cnt_dec      = 1'b0;
    pos_move     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (op_kind == OP_HOME) begin
            cnt_load     = 1'b1;
            cnt_load_val = CNT_W'(position);
            state_d      = ST_CHECK;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        cnt_load     = 1'b1;
        cnt_load_val = CNT_W'(cmd_nib);
        state_d      = ST_CHECK;
      end
      ST_CHECK: begin
        if (cnt_zero || limit_hit) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_PULSE;
        end
      end
      ST_PULSE: begin
        cnt_dec  = 1'b1;
        pos_move = 1'b1;
        state_d  = ST_CHECK;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Direction level is chosen when a command is accepted and then held
  assign dir_en = accept;
  assign dir_d  = (op_kind == OP_IN);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q <= 1'b0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign step      = (state_q == ST_PULSE);
  assign direction = dir_q;

endmodule

// File: rtl/stepper_ctrl_chk.sv
module stepper_ctrl_chk #(
  parameter int NIB_W = 4,
  parameter int POS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NIB_W-1:0] cmd_nib,
  input logic             strobe,
  input logic             busy,
  input logic             step,
  input logic             direction,
  input logic [POS_W-1:0] position
);

  logic known_op;
  assign known_op = (cmd_nib == NIB_W'(4'b1000)) ||
                    (cmd_nib == NIB_W'(4'b0100)) ||
                    (cmd_nib == NIB_W'(4'b0010));

  // R5: a pulse lasts one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  // R5: direction settled before and during each pulse
  a_r5_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $stable(direction));

  // R10: no pulse while the controller reports idle
  a_r10_no_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !step);

  // R6: inward pulse raises the position by one
  a_r6_pos_inward: assert property (@(posedge clk) disable iff (!rst_n)
    (step && direction) |=> (position == POS_W'($past(position) + 1'b1)));

  // R6: outward pulse lowers the position by one
  a_r6_pos_outward: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !direction) |=> (position == POS_W'($past(position) - 1'b1)));

  // R6: position holds when no pulse is issued
  a_r6_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(position));

  // R7: no inward pulse at the inner limit
  a_r7_upper_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step && direction) |-> (position != '1));

  // R7: no outward pulse at the outer limit
  a_r7_lower_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !direction) |-> (position != '0));

  // R9: undefined opcodes leave the controller idle
  a_r9_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && strobe && !known_op) |=> !busy);

endmodule

bind stepper_cmd_ctrl stepper_ctrl_chk #(
  .NIB_W (NIB_W),
  .POS_W (POS_W)
) u_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_nib   (cmd_nib),
  .strobe    (strobe),
  .busy      (busy),
  .step      (step),
  .direction (direction),
  .position  (position)
);

// File: tb/stepper_cmd_ctrl_tb_top.sv
module stepper_cmd_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NROWS      = 12;
  localparam int WATCHDOG   = 150000;

  // Row layout: opcode[18:15] count[14:11] valid[10] pulses[9:5] dir[4] pos[3:0]
  localparam logic [18:0] VEC [NROWS] = '{
    {4'b1000, 4'd5,  1'b1, 5'd5,  1'b1, 4'd5 },
    {4'b0100, 4'd2,  1'b1, 5'd2,  1'b0, 4'd3 },
    {4'b1000, 4'd0,  1'b1, 5'd0,  1'b1, 4'd3 },
    {4'b1000, 4'd15, 1'b1, 5'd12, 1'b1, 4'd15},
    {4'b1000, 4'd3,  1'b1, 5'd0,  1'b1, 4'd15},
    {4'b0010, 4'd0,  1'b1, 5'd15, 1'b0, 4'd0 },
    {4'b0010, 4'd0,  1'b1, 5'd0,  1'b0, 4'd0 },
    {4'b0100, 4'd4,  1'b1, 5'd0,  1'b0, 4'd0 },
    {4'b0001, 4'd0,  1'b0, 5'd0,  1'b0, 4'd0 },
    {4'b1000, 4'd9,  1'b1, 5'd9,  1'b1, 4'd9 },
    {4'b1100, 4'd0,  1'b0, 5'd0,  1'b0, 4'd9 },
    {4'b0100, 4'd9,  1'b1, 5'd9,  1'b0, 4'd0 }
  };

  logic       clk;
  logic       rst_n;
  logic [3:0] cmd_nib;
  logic       strobe;
  logic       busy;
  logic       step;
  logic       direction;
  logic [3:0] position;

  int checks;
  int failures;
  bit finished;

  stepper_cmd_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_nib   (cmd_nib),
    .strobe    (strobe),
    .busy      (busy),
    .step      (step),
    .direction (direction),
    .position  (position)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [3:0] op, input logic [3:0] cnt, input bit exp_valid,
                         input int exp_pulses, input bit exp_dir, input logic [3:0] exp_pos,
                         input bit inject);
    bit has_arg;
    int pulses;
    int last_pulse;
    int busy_low;
    bit prev_step;
    bit prev_dir;
    bit dir_bad;
    bit back2back;
    has_arg    = (op == 4'b1000) || (op == 4'b0100);
    pulses     = 0;
    last_pulse = -1;
    busy_low   = -1;
    prev_step  = 1'b0;
    dir_bad    = 1'b0;
    back2back  = 1'b0;
    @(negedge clk);
    cmd_nib = op;
    strobe  = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(busy == exp_valid, exp_valid ? "R2 busy after accept" : "R9 busy after bad opcode",
          int'(busy), int'(exp_valid));
    if (exp_valid && has_arg) begin
      cmd_nib = cnt;
      @(negedge clk);
      // R3: the bus now carries junk; the count must already be held
      cmd_nib = 4'hF;
    end
    if (inject) begin
      // R10: a return-to-zero strobe while busy must be ignored
      cmd_nib = 4'b0010;
      strobe  = 1'b1;
    end
    prev_dir = direction;
    for (int c = 0; c < 80; c++) begin
      if (step) begin
        pulses++;
        if (prev_step) back2back = 1'b1;
        if (direction !== exp_dir || prev_dir !== exp_dir) dir_bad = 1'b1;
        last_pulse = c;
      end
      if (!busy) begin
        busy_low = c;
        break;
      end
      prev_step = step;
      prev_dir  = direction;
      @(negedge clk);
      strobe  = 1'b0;
      cmd_nib = 4'hF;
    end
    check(pulses == exp_pulses, "R4/R7/R8 pulse count", pulses, exp_pulses);
    check(position == exp_pos, "R6/R7/R8/R9 final position", int'(position), int'(exp_pos));
    if (exp_valid) begin
      check(busy_low >= 0, "R10 busy released", busy_low, 0);
      check(direction == exp_dir, "R2 direction level", int'(direction), int'(exp_dir));
    end
    if (exp_pulses > 0) begin
      check(!dir_bad, "R5 direction settled around pulses", int'(dir_bad), 0);
      check(!back2back, "R5 low cycle between pulses", int'(back2back), 0);
      check(busy_low - last_pulse == 2, "R10 busy drop timing", busy_low - last_pulse, 2);
    end
    if (!exp_valid) begin
      repeat (3) begin
        @(negedge clk);
        check(!busy, "R9 busy stays low", int'(busy), 0);
      end
    end
  endtask

  task automatic check_reset_outputs(input string tag);
    check(busy == 1'b0, tag, int'(busy), 0);
    check(step == 1'b0, tag, int'(step), 0);
    check(direction == 1'b0, tag, int'(direction), 0);
    check(position == 4'd0, tag, int'(position), 0);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    strobe   = 1'b0;
    cmd_nib  = 4'h0;
    repeat (3) @(negedge clk);
    check_reset_outputs("R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_outputs("R1 state after release");

    // Vector table walk
    for (int i = 0; i < NROWS; i++) begin
      run_cmd(VEC[i][18:15], VEC[i][14:11], VEC[i][10], int'(VEC[i][9:5]),
              VEC[i][4], VEC[i][3:0], 1'b0);
    end

    // R10: strobe of a return-to-zero during a move is ignored
    run_cmd(4'b1000, 4'd3, 1'b1, 3, 1'b1, 4'd3, 1'b1);
    // R8: return to zero from a mid position
    run_cmd(4'b0010, 4'd0, 1'b1, 3, 1'b0, 4'd0, 1'b0);
    // R4: two-nibble move out of two steps from position 6
    run_cmd(4'b1000, 4'd6, 1'b1, 6, 1'b1, 4'd6, 1'b0);
    run_cmd(4'b0100, 4'b0010, 1'b1, 2, 1'b0, 4'd4, 1'b0);

    // R1: asynchronous reset in the middle of a command
    @(negedge clk);
    cmd_nib = 4'b1000;
    strobe  = 1'b1;
    @(negedge clk);
    strobe  = 1'b0;
    cmd_nib = 4'd7;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check_reset_outputs("R1 asynchronous clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_outputs("R1 clear held after release");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule